// File: doc/BRIEF.md
# Write-only I2C Command Receiver with Retrace-Locked Clock Stretching

This block is an I2C target that only ever receives. A system clock oversamples the SCL and SDA lines through synchronizers, and the block pulls either line low through drive-low enables. After a START it takes in an address byte and accepts it only for its own fixed address. Each data byte that follows is acknowledged and handed to a downstream command interpreter as a one-cycle strobe with the byte.

The interpreter can flag the byte that is on its way as a display-memory write. Such a byte is not issued when it completes. The block instead stretches SCL low and waits for the horizontal retrace of the video timing (HSYNC active while VSYNC is inactive). When the retrace arrives, it issues the byte on a separate memory-write strobe and releases SCL. Display memory is therefore only written during the retrace. Reads, general call and arbitration between several masters are not handled.

Top module: `osd_i2c_rx`

## Requirements
- R1: During reset and right after it, the block drives neither SCL nor SDA low, and both `cmdValid` and `ramWrite` are low.
- R2: An address byte whose upper seven bits are 1011101 (0x5D) and whose last bit (R/W) is 0 is acknowledged: SDA is held low through the ninth SCL pulse.
- R3: An address byte of 0x5D with R/W = 1 is acknowledged only while `testMode` is high. With `testMode` low it gets no acknowledge.
- R4: An address byte with any other upper seven bits gets no acknowledge. The bytes that follow it get no acknowledge and raise no strobe until the next START.
- R5: Bits are taken most significant first, on the rising edge of SCL. A data byte for which `ramNext` is low at the SCL falling edge after its eighth bit is acknowledged. That byte also appears on `cmdData` together with a one-cycle `cmdValid`.
- R6: A data byte for which `ramNext` is high at that falling edge makes the block hold SCL low until `hsync` is high while `vsync` is low. It then gives a one-cycle `ramWrite` with the byte on `ramData`, releases SCL and acknowledges the byte.
- R7: `ramWrite` rises only when `hsync` was high and `vsync` was low at the clock edge that issued it. While `vsync` is high, a held byte stays held.
- R8: A STOP returns the block to waiting for a START. Bytes clocked after a STOP without a new START get no acknowledge and raise no strobe.
- R9: A START or STOP seen after two or more bits of a byte have been shifted is a bus error. The partial byte is dropped and the block ignores the bus until the next START. A START at a byte boundary (repeated START) begins a new address phase.
- R10: `cmdValid` and `ramWrite` are never high together, and each lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | SCL line as seen on the bus |
| sdaIn | input | 1 | SDA line as seen on the bus |
| sclDriveLow | output | 1 | Pulls SCL low when high (clock stretch) |
| sdaDriveLow | output | 1 | Pulls SDA low when high (acknowledge) |
| testMode | input | 1 | Allows R/W = 1 in the address byte |
| ramNext | input | 1 | From the interpreter: the current byte is a display-memory write |
| hsync | input | 1 | Horizontal sync, active high, synchronous to clk |
| vsync | input | 1 | Vertical sync, active high, synchronous to clk |
| cmdValid | output | 1 | One-cycle strobe for a command byte |
| cmdData | output | 8 | Command byte |
| ramWrite | output | 1 | One-cycle display-memory write strobe |
| ramData | output | 8 | Display-memory byte |

## Verification
The assertions assume a master that follows the bus rules:
- it changes SDA only while SCL is low, except for START and STOP;
- it keeps each SCL level for many system clocks;
- it waits for the line to read high after releasing SCL, so a stretch is honoured;
- `hsync` and `vsync` are synchronous to `clk`.

The bench keeps within these rules. Its open-drain master model spaces every edge by ten system clocks and polls the wired-AND SCL line before it moves on. The video timing is produced from a clock-aligned counter, or set by hand between clock edges. Random byte values and random command/memory choices run on top of a few hand-built bus-error and stretch scenarios.

// File: rtl/osd_i2c_pkg.sv
package osd_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_ACK,
    ST_HOLD
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;
    logic clrCnt;
    logic issueCmd;
    logic issueRam;
  } dpCtl_t;

endpackage

// File: rtl/osd_i2c_dp.sv
module osd_i2c_dp
  import osd_i2c_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] OWN_ADDR = 7'b1011101,
  parameter int SYNC_STAGES = 2,
  localparam int DATA_W = ADDR_W + 1,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtl_t            ctl,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              addrHit,
  output logic              rwBit,
  output logic              cmdValid,
  output logic [DATA_W-1:0] cmdData,
  output logic              ramWrite,
  output logic [DATA_W-1:0] ramData
);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclP, sdaP;
  logic [DATA_W-1:0] shiftReg;

  // synchronizers, idle bus level is high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclP    <= sclS;
      sdaP    <= sdaS;
    end
  end

  assign sclS     = sclSync[SYNC_STAGES-1];
  assign sdaS     = sdaSync[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;
  assign startDet = sclS & sclP & sdaP & ~sdaS;
  assign stopDet  = sclS & sclP & ~sdaP & sdaS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else begin
      if (ctl.shiftEn) shiftReg <= {shiftReg[DATA_W-2:0], sdaS};
      if (ctl.clrCnt) bitCnt <= '0;
      else if (ctl.shiftEn) bitCnt <= bitCnt + 1'b1;
    end
  end

  assign addrHit = (shiftReg[DATA_W-1:1] == OWN_ADDR);
  assign rwBit   = shiftReg[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      ramWrite <= 1'b0;
      cmdData  <= '0;
      ramData  <= '0;
    end else begin
      cmdValid <= ctl.issueCmd;
      ramWrite <= ctl.issueRam;
      if (ctl.issueCmd) cmdData <= shiftReg;
      if (ctl.issueRam) ramData <= shiftReg;
    end
  end

endmodule

// File: rtl/osd_i2c_ctrl.sv
module osd_i2c_ctrl
  import osd_i2c_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclRise,
  input  logic             sclFall,
  input  logic             startDet,
  input  logic             stopDet,
  input  logic [CNT_W-1:0] bitCnt,
  input  logic             addrHit,
  input  logic             rwBit,
  input  logic             testMode,
  input  logic             ramNext,
  input  logic             hsync,
  input  logic             vsync,
  output dpCtl_t           ctl,
  output logic             sclDriveLow,
  output logic             sdaDriveLow
);

  rxState_t state, nextState;
  logic inByte, byteFull, midByte, retrace;

  assign inByte   = (state == ST_ADDR) || (state == ST_DATA);
  assign byteFull = (bitCnt == CNT_W'(DATA_W));
  // one rise is always seen before a repeated START or a STOP
  assign midByte  = inByte && (bitCnt >= CNT_W'(2));
  assign retrace  = hsync && !vsync;

  always_comb begin
    nextState = state;
    ctl       = '0;
    if (stopDet) begin
      nextState = ST_IDLE;
    end else if (startDet) begin
      if (midByte) nextState = ST_IDLE;
      else begin
        nextState  = ST_ADDR;
        ctl.clrCnt = 1'b1;
      end
    end else begin
      unique case (state)
        ST_ADDR, ST_DATA: begin
          if (sclRise && !byteFull) ctl.shiftEn = 1'b1;
          if (sclFall && byteFull) begin
            if (state == ST_ADDR) begin
              nextState = (addrHit && (!rwBit || testMode)) ? ST_ACK : ST_IDLE;
            end else if (ramNext) begin
              nextState = ST_HOLD;
            end else begin
              ctl.issueCmd = 1'b1;
              nextState    = ST_ACK;
            end
          end
        end
        ST_HOLD: begin
          if (retrace) begin
            ctl.issueRam = 1'b1;
            nextState    = ST_ACK;
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            ctl.clrCnt = 1'b1;
            nextState  = ST_DATA;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else state <= nextState;
  end

  assign sclDriveLow = (state == ST_HOLD);
  assign sdaDriveLow = (state == ST_ACK) || (state == ST_HOLD);

endmodule

// File: rtl/osd_i2c_rx.sv
module osd_i2c_rx
  import osd_i2c_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] OWN_ADDR = 7'b1011101,
  parameter int SYNC_STAGES = 2,
  localparam int DATA_W = ADDR_W + 1,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  input  logic              testMode,
  input  logic              ramNext,
  input  logic              hsync,
  input  logic              vsync,
  output logic              cmdValid,
  output logic [DATA_W-1:0] cmdData,
  output logic              ramWrite,
  output logic [DATA_W-1:0] ramData
);

  dpCtl_t ctl;
  logic sclRise, sclFall, startDet, stopDet, addrHit, rwBit;
  logic [CNT_W-1:0] bitCnt;

  osd_i2c_dp #(
    .ADDR_W(ADDR_W), .OWN_ADDR(OWN_ADDR), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ctl(ctl),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .bitCnt(bitCnt), .addrHit(addrHit), .rwBit(rwBit),
    .cmdValid(cmdValid), .cmdData(cmdData), .ramWrite(ramWrite), .ramData(ramData)
  );

  osd_i2c_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .bitCnt(bitCnt),
    .addrHit(addrHit), .rwBit(rwBit), .testMode(testMode), .ramNext(ramNext),
    .hsync(hsync), .vsync(vsync), .ctl(ctl),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow)
  );

endmodule

// File: rtl/osd_i2c_rx_chk.sv
module osd_i2c_rx_chk (
  input logic clk,
  input logic rstN,
  input logic sclDriveLow,
  input logic sdaDriveLow,
  input logic cmdValid,
  input logic ramWrite,
  input logic hsync,
  input logic vsync
);

  assert_reset_R1: assert property (@(posedge clk)
    !rstN |=> !sclDriveLow && !sdaDriveLow && !cmdValid && !ramWrite);

  assert_cmd_ack_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> sdaDriveLow);

  assert_stretch_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    sclDriveLow && !(hsync && !vsync) |=> sclDriveLow);

  assert_stretch_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclDriveLow) |-> ramWrite && sdaDriveLow);

  assert_stretch_ack_R6: assert property (@(posedge clk) disable iff (!rstN)
    sclDriveLow |-> sdaDriveLow);

  assert_ram_window_R7: assert property (@(posedge clk) disable iff (!rstN)
    ramWrite |-> $past(hsync) && !$past(vsync));

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && ramWrite));

  assert_cmd_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  assert_ram_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    ramWrite |=> !ramWrite);

endmodule

bind osd_i2c_rx osd_i2c_rx_chk u_chk (
  .clk(clk), .rstN(rstN), .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
  .cmdValid(cmdValid), .ramWrite(ramWrite), .hsync(hsync), .vsync(vsync)
);

// File: tb/osd_i2c_rx_bench.sv
`timescale 1ns/1ps
module osd_i2c_rx_bench;

  localparam int Q = 10;
  localparam logic [7:0] MY_ADDR = 8'hBA; // 0x5D, write

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mSclLow = 1'b0, mSdaLow = 1'b0;
  logic sclDriveLow, sdaDriveLow, testMode, ramNext;
  logic hsync, vsync, cmdValid, ramWrite;
  logic [7:0] cmdData, ramData;
  logic sclLine, sdaLine;
  logic vidAuto = 1'b1, hsMan = 1'b0, vsMan = 1'b0;
  int vidCnt = 0;
  logic hsEdge = 1'b0, vsEdge = 1'b0;

  int checks = 0, errors = 0;
  logic [7:0] cmdGot [0:511];
  logic [7:0] ramGot [0:511];
  logic [7:0] cmdExp [0:511];
  logic [7:0] ramExp [0:511];
  int cmdN = 0, ramN = 0, cmdE = 0, ramE = 0;
  logic holdAck, holdDone;

  always #2.5 clk = ~clk;

  assign sclLine = !(mSclLow || sclDriveLow);
  assign sdaLine = !(mSdaLow || sdaDriveLow);
  assign hsync = vidAuto ? ((vidCnt % 200) < 40) : hsMan;
  assign vsync = vidAuto ? (((vidCnt / 200) % 4) == 0) : vsMan;

  always @(posedge clk) #1 vidCnt <= vidCnt + 1;

  osd_i2c_rx u_osd_i2c_rx (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .testMode(testMode), .ramNext(ramNext), .hsync(hsync), .vsync(vsync),
    .cmdValid(cmdValid), .cmdData(cmdData), .ramWrite(ramWrite), .ramData(ramData)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit addrAckExp(input logic [7:0] b, input logic tm);
    return (b[7:1] == 7'h5D) && (!b[0] || tm);
  endfunction

  // monitor: video level seen at the issuing edge, strobes at negedge
  always @(posedge clk) begin
    hsEdge = hsync;
    vsEdge = vsync;
  end

  always @(negedge clk) begin
    if (rstN && cmdValid) begin
      cmdGot[cmdN] = cmdData;
      cmdN++;
    end
    if (rstN && ramWrite) begin
      ramGot[ramN] = ramData;
      ramN++;
      chk(hsEdge && !vsEdge, "R7 ramWrite outside retrace", {hsEdge, vsEdge}, 2'b10);
    end
    if (rstN) chk(!(cmdValid && ramWrite), "R10 both strobes", 1, 0);
  end

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic sclHigh();
    mSclLow = 1'b0;
    while (!sclLine) @(negedge clk);
    waitQ();
  endtask

  task automatic doStart();
    mSdaLow = 1'b0; waitQ();
    sclHigh();
    mSdaLow = 1'b1; waitQ();
    mSclLow = 1'b1; waitQ();
  endtask

  task automatic doStop();
    mSdaLow = 1'b1; waitQ();
    sclHigh();
    mSdaLow = 1'b0; waitQ();
  endtask

  task automatic sendBit(input logic b);
    mSdaLow = !b; waitQ();
    sclHigh();
    mSclLow = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    mSdaLow = 1'b0; waitQ();
    sclHigh();
    ack = !sdaLine;
    mSclLow = 1'b1; waitQ();
  endtask

  task automatic sendCmd(input logic [7:0] b, input string tag);
    logic a;
    ramNext = 1'b0;
    sendByte(b, a);
    chk(a == 1'b1, tag, a, 1);
    cmdExp[cmdE] = b; cmdE++;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    int c0, r0;
    void'($urandom(32'h0C5D_2024));
    testMode = 1'b0; ramNext = 1'b0;
    repeat (5) @(negedge clk);
    // R1: idle outputs while in reset and after release
    chk(!sclDriveLow && !sdaDriveLow && !cmdValid && !ramWrite, "R1 in reset",
        {sclDriveLow, sdaDriveLow, cmdValid, ramWrite}, 0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    chk(!sclDriveLow && !sdaDriveLow && !cmdValid && !ramWrite, "R1 after reset",
        {sclDriveLow, sdaDriveLow, cmdValid, ramWrite}, 0);

    // R2 / R5: own address, two command bytes
    doStart();
    sendByte(MY_ADDR, a);
    chk(a == addrAckExp(MY_ADDR, 1'b0), "R2 address ack", a, 1);
    sendCmd(8'h81, "R5 cmd ack");
    sendCmd(8'h7E, "R5 cmd ack");
    doStop();

    // R3: read bit without and with test mode
    doStart();
    sendByte(8'hBB, a);
    chk(a == addrAckExp(8'hBB, 1'b0), "R3 read nack", a, 0);
    doStop();
    testMode = 1'b1;
    doStart();
    sendByte(8'hBB, a);
    chk(a == addrAckExp(8'hBB, 1'b1), "R3 read ack in test", a, 1);
    sendCmd(8'h5A, "R3 byte after test address");
    doStop();
    testMode = 1'b0;

    // R4: foreign address, following byte ignored
    c0 = cmdN;
    doStart();
    sendByte(8'hB8, a);
    chk(a == addrAckExp(8'hB8, 1'b0), "R4 foreign nack", a, 0);
    sendByte(8'h33, a);
    chk(a == 1'b0, "R4 following byte nack", a, 0);
    doStop();
    repeat (5) @(negedge clk);
    chk(cmdN == c0, "R4 no strobe", cmdN, c0);

    // R8: byte after STOP without START
    sendByte(MY_ADDR, a);
    chk(a == 1'b0, "R8 no ack without start", a, 0);
    repeat (5) @(negedge clk);
    chk(cmdN == c0, "R8 no strobe", cmdN, c0);
    doStop();

    // R9: START after three data bits is a bus error
    doStart();
    sendByte(MY_ADDR, a);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    doStart();
    sendByte(MY_ADDR, a);
    chk(a == 1'b0, "R9 ignored after bus error", a, 0);
    repeat (5) @(negedge clk);
    chk(cmdN == c0, "R9 partial byte dropped", cmdN, c0);
    doStop();
    // R9: repeated START at a byte boundary
    doStart();
    sendByte(MY_ADDR, a);
    sendCmd(8'h11, "R9 before repeated start");
    doStart();
    sendByte(MY_ADDR, a);
    chk(a == 1'b1, "R9 repeated start address ack", a, 1);
    sendCmd(8'h22, "R9 after repeated start");
    doStop();

    // R6 / R7: manual video timing, stretched memory write
    vidAuto = 1'b0; hsMan = 1'b0; vsMan = 1'b0;
    r0 = ramN;
    doStart();
    sendByte(MY_ADDR, a);
    ramNext = 1'b1;
    holdDone = 1'b0;
    fork
      begin
        sendByte(8'h3C, holdAck);
        holdDone = 1'b1;
      end
    join_none
    repeat (400) @(negedge clk);
    chk(sclDriveLow == 1'b1, "R6 SCL held before hsync", sclDriveLow, 1);
    chk(ramN == r0, "R6 no write before hsync", ramN, r0);
    hsMan = 1'b1; vsMan = 1'b1;
    repeat (60) @(negedge clk);
    chk(sclDriveLow == 1'b1, "R7 held while vsync active", sclDriveLow, 1);
    chk(ramN == r0, "R7 no write during vsync", ramN, r0);
    vsMan = 1'b0;
    while (!holdDone) @(negedge clk);
    ramNext = 1'b0;
    chk(holdAck == 1'b1, "R6 ack after release", holdAck, 1);
    chk(ramN == r0 + 1, "R6 one write", ramN, r0 + 1);
    chk(ramGot[r0] == 8'h3C, "R6 write data", ramGot[r0], 8'h3C);
    chk(!sclDriveLow, "R6 SCL released", sclDriveLow, 0);
    hsMan = 1'b0;
    doStop();
    vidAuto = 1'b1;
    r0 = ramN;

    // random transfers on free-running video timing
    for (int t = 0; t < 25; t++) begin
      int nb;
      nb = 1 + ($urandom % 3);
      doStart();
      sendByte(MY_ADDR, a);
      chk(a == 1'b1, "R2 random address ack", a, 1);
      for (int k = 0; k < nb; k++) begin
        logic [7:0] d;
        logic isRam;
        d = 8'($urandom);
        isRam = (($urandom % 3) == 0);
        ramNext = isRam;
        sendByte(d, a);
        ramNext = 1'b0;
        chk(a == 1'b1, isRam ? "R6 random ram ack" : "R5 random cmd ack", a, 1);
        if (isRam) begin ramExp[ramE] = d; ramE++; end
        else begin cmdExp[cmdE] = d; cmdE++; end
      end
      doStop();
    end
    repeat (20) @(negedge clk);

    chk(cmdN == cmdE, "R5 command count", cmdN, cmdE);
    for (int i = 0; i < cmdE; i++)
      chk(cmdGot[i] == cmdExp[i], "R5 command data", cmdGot[i], cmdExp[i]);
    chk(ramN - r0 == ramE, "R6 write count", ramN - r0, ramE);
    for (int i = 0; i < ramE; i++)
      chk(ramGot[r0 + i] == ramExp[i], "R6 write data", ramGot[r0 + i], ramExp[i]);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule